// File: doc/BRIEF.md
# Iterative Unit Occupancy Scoreboard

This block keeps issue-time bookkeeping for a core whose long-latency arithmetic runs on two iterative engines that are not pipelined. One engine serves integer multiply and divide. The other is shared by float multiply, float divide/square-root and float reciprocal square root. Each accepted operation reserves its engine for a number of cycles that depends on both the operation and its precision (32/64-bit or single/double). Any later operation that needs a busy engine is refused with a stall until the engine frees up.

Alongside the engines, the block holds one down-counter per destination register. An accepted operation loads its destination's counter with the operation's result latency. The register's ready flag is raised when the counter reaches zero, which is the earliest cycle in which a dependent instruction may issue. Decode, pairing and the arithmetic itself live elsewhere. The scoreboard only sees an issue strobe carrying an operation class, a precision bit and a destination index.

All timing is counted from the issue cycle. An operation with occupancy N that is accepted in cycle c holds its engine through cycle c+N-1, so the engine accepts again in cycle c+N. An operation with latency L that is accepted in cycle c holds its destination not-ready through cycle c+L-1, and the destination becomes ready in cycle c+L.

Top module: `occ_scoreboard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every `reg_rdy` bit is 1 and `stall` is 0 when `iss_vld` is 0.
- R2: `iss_op` codes: 0 simple integer, 1 load, 2 branch, 3 move to the multiply result registers, 4 float add/compare/convert, 5 integer multiply, 6 integer divide, 7 float multiply, 8 float divide/sqrt, 9 float reciprocal sqrt; codes 10 to 15 behave like code 0. Codes 0, 1, 2, 3 and 4 have latencies 1, 2, 3, 3 and 4. A destination issued in cycle c with latency L has `reg_rdy` 0 in cycles c+1 to c+L-1 and 1 from cycle c+L.
- R3: Integer multiply (code 5) occupies the integer engine for 3 cycles with latency 5 when `iss_dbl` is 0, and for 8 cycles with latency 9 when `iss_dbl` is 1.
- R4: Integer divide (code 6) occupies the integer engine for 36 cycles when `iss_dbl` is 0 and for 68 cycles when `iss_dbl` is 1. Its latency equals its occupancy.
- R5: Float multiply (code 7) occupies the float engine for 1 cycle with latency 4 in single precision (`iss_dbl` 0), and for 2 cycles with latency 5 in double precision. Two single multiplies can issue in consecutive cycles.
- R6: Float divide/sqrt (code 8) occupies the float engine for 21 cycles in single precision and 36 in double. Float reciprocal sqrt (code 9) occupies it for 38 in single and 68 in double. Latency equals occupancy for both.
- R7: `stall` is 1 in exactly those cycles where `iss_vld` is 1 and the operation's engine is still occupied. A stalled operation changes no engine and no destination ready flag.
- R8: The two engines are independent. A float engine operation is not stalled by a busy integer engine, and an integer engine operation is not stalled by a busy float engine.
- R9: Float multiply, divide/sqrt and reciprocal sqrt share the float engine. Each stalls behind an unfinished one of the others.
- R10: A new accepted operation to a destination replaces that destination's remaining countdown with its own latency. It does not shorten the occupancy of any engine.
- R11: Codes 0 to 4 and 10 to 15 never stall, even while both engines are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An operation is offered for issue this cycle |
| iss_op | input | 4 | Operation class code (see R2) |
| iss_dbl | input | 1 | 1 for 64-bit / double precision, 0 for 32-bit / single |
| iss_dst | input | $clog2(NREG) | Destination register index |
| stall | output | 1 | Offered operation refused: its engine is occupied |
| reg_rdy | output | NREG | Per-register ready flag for dependent instructions |

## Verification
The bench builds the block with NREG set to 8. With that value, every destination counter in the instance is loaded, overwritten or probed within one run, and each probe can be aimed at a register known to be ready. The timing constants stay at their true values, so the bench crosses the full 68-cycle windows of the longest integer divide and the longest reciprocal square root. It also places probes one cycle before and at the release of each engine. Engine release times overlap between the two engines, so the independence and the sharing rules are exercised while the other engine is still counting.

// File: rtl/occ_pkg.sv
package occ_pkg;

  // Operation class codes seen on the issue port
  typedef enum logic [3:0] {
    OP_ALU      = 4'd0,
    OP_LOAD     = 4'd1,
    OP_BRANCH   = 4'd2,
    OP_HILO     = 4'd3,
    OP_FPSIMPLE = 4'd4,
    OP_IMUL     = 4'd5,
    OP_IDIV     = 4'd6,
    OP_FMUL     = 4'd7,
    OP_FDIV     = 4'd8,
    OP_FRSQRT   = 4'd9
  } op_e;

  localparam int OP_W = 4;

  // Occupancy / latency constants in cycles
  localparam int T_ALU      = 1;
  localparam int T_LOAD     = 2;
  localparam int T_BRANCH   = 3;
  localparam int T_HILO     = 3;
  localparam int T_FPSIMPLE = 4;
  localparam int O_IMUL_S   = 3;
  localparam int L_IMUL_S   = 5;
  localparam int O_IMUL_D   = 8;
  localparam int L_IMUL_D   = 9;
  localparam int T_IDIV_S   = 36;
  localparam int T_IDIV_D   = 68;
  localparam int O_FMUL_S   = 1;
  localparam int L_FMUL_S   = 4;
  localparam int O_FMUL_D   = 2;
  localparam int L_FMUL_D   = 5;
  localparam int T_FDIV_S   = 21;
  localparam int T_FDIV_D   = 36;
  localparam int T_FRSQ_S   = 38;
  localparam int T_FRSQ_D   = 68;

  localparam int MAX_CYC = 68;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic use_int;  // needs the integer iterative engine
    logic use_flt;  // needs the float iterative engine
    cnt_t occ;      // engine occupancy in cycles (0 when no engine)
    cnt_t lat;      // result latency in cycles (>= 1)
  } tinfo_t;

endpackage

// File: rtl/occ_decode.sv
module occ_decode
  import occ_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            dbl,
  output tinfo_t          info
);

  always_comb begin
    info = '{use_int: 1'b0, use_flt: 1'b0, occ: '0, lat: cnt_t'(T_ALU)};
    case (op)
      OP_LOAD:     info.lat = cnt_t'(T_LOAD);
      OP_BRANCH:   info.lat = cnt_t'(T_BRANCH);
      OP_HILO:     info.lat = cnt_t'(T_HILO);
      OP_FPSIMPLE: info.lat = cnt_t'(T_FPSIMPLE);
      OP_IMUL: begin
        info.use_int = 1'b1;
        info.occ     = dbl ? cnt_t'(O_IMUL_D) : cnt_t'(O_IMUL_S);
        info.lat     = dbl ? cnt_t'(L_IMUL_D) : cnt_t'(L_IMUL_S);
      end
      OP_IDIV: begin
        info.use_int = 1'b1;
        info.occ     = dbl ? cnt_t'(T_IDIV_D) : cnt_t'(T_IDIV_S);
        info.lat     = info.occ;
      end
      OP_FMUL: begin
        info.use_flt = 1'b1;
        info.occ     = dbl ? cnt_t'(O_FMUL_D) : cnt_t'(O_FMUL_S);
        info.lat     = dbl ? cnt_t'(L_FMUL_D) : cnt_t'(L_FMUL_S);
      end
      OP_FDIV: begin
        info.use_flt = 1'b1;
        info.occ     = dbl ? cnt_t'(T_FDIV_D) : cnt_t'(T_FDIV_S);
        info.lat     = info.occ;
      end
      OP_FRSQRT: begin
        info.use_flt = 1'b1;
        info.occ     = dbl ? cnt_t'(T_FRSQ_D) : cnt_t'(T_FRSQ_S);
        info.lat     = info.occ;
      end
      default: ;  // ALU and unused codes: latency 1, no engine
    endcase
  end

endmodule

// File: rtl/occ_down_cnt.sv
module occ_down_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // next-state
  always_comb begin
    cnt_en = ld | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (ld)
      cnt_d = ld_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val)); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !zero) |=> cnt_q == $past(cnt_q) - W'(1)); // R2

  AST_CNT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && zero) |=> zero); // R7

endmodule

// File: rtl/occ_scoreboard.sv
module occ_scoreboard
  import occ_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_vld,
  input  logic [3:0]              iss_op,
  input  logic                    iss_dbl,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  output logic                    stall,
  output logic [NREG-1:0]         reg_rdy
);

  localparam int REG_W = $clog2(NREG);

  tinfo_t info;
  logic   int_free;
  logic   flt_free;
  logic   accept;
  cnt_t   eng_val;
  cnt_t   reg_val;

  occ_decode u_dec (
    .op   (iss_op),
    .dbl  (iss_dbl),
    .info (info)
  );

  // structural hazard check against the two engines
  always_comb begin
    stall   = iss_vld & ((info.use_int & ~int_free) | (info.use_flt & ~flt_free));
    accept  = iss_vld & ~stall;
    eng_val = info.occ - cnt_t'(1);
    reg_val = info.lat - cnt_t'(1);
  end

  occ_down_cnt #(.W(CNT_W)) u_int_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (accept & info.use_int),
    .ld_val (eng_val),
    .zero   (int_free)
  );

  occ_down_cnt #(.W(CNT_W)) u_flt_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (accept & info.use_flt),
    .ld_val (eng_val),
    .zero   (flt_free)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    occ_down_cnt #(.W(CNT_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (accept && (iss_dst == REG_W'(g))),
      .ld_val (reg_val),
      .zero   (reg_rdy[g])
    );
  end

  AST_STALL_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> iss_vld); // R7

  AST_SIMPLE_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !info.use_int && !info.use_flt) |-> !stall); // R11

  AST_DST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && info.lat > cnt_t'(1)) |=> !reg_rdy[$past(iss_dst)]); // R2

  AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && info.use_int && info.occ > cnt_t'(1)) |=> !int_free); // R3

  AST_FLT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && info.use_flt && info.occ > cnt_t'(1)) |=> !flt_free); // R9

  AST_OCC_WITHIN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |-> (info.occ <= info.lat) && (info.lat != '0)); // R6

  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |-> !(info.use_int && info.use_flt)); // R8

endmodule

// File: tb/occ_scoreboard_test.sv
`timescale 1ns/1ps
module occ_scoreboard_test;

  localparam int NREG = 8;

  logic             clk;
  logic             rst_n;
  logic             iss_vld;
  logic [3:0]       iss_op;
  logic             iss_dbl;
  logic [2:0]       iss_dst;
  logic             stall;
  logic [NREG-1:0]  reg_rdy;

  occ_scoreboard #(.NREG(NREG)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_vld (iss_vld),
    .iss_op  (iss_op),
    .iss_dbl (iss_dbl),
    .iss_dst (iss_dst),
    .stall   (stall),
    .reg_rdy (reg_rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int    cyc;
    int    kind;  // 0 stall, 1 one ready bit, 2 whole ready vector
    int    idx;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc   = 0;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input int k, input int i, input int v, input string t);
    exp_t e;
    e.cyc = c; e.kind = k; e.idx = i; e.val = v; e.tag = t;
    q.push_back(e);
  endtask

  // monitor: compare expectations due in the current cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        int act;
        case (q[i].kind)
          0:       act = int'(stall);
          1:       act = int'(reg_rdy[q[i].idx]);
          default: act = int'(reg_rdy);
        endcase
        total++;
        if (act != q[i].val) begin
          bad++;
          $display("FAIL %s cycle %0d kind %0d idx %0d: actual=%0d expected=%0d",
                   q[i].tag, cyc, q[i].kind, q[i].idx, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic waitto(input int t);
    while (cyc < t) step();
  endtask

  // driver: offers one operation for one cycle and queues its expectations
  task automatic do_issue(input int op, input bit dbl, input int dst,
                          input bit exp_stall, input int lat, input bit chk,
                          input string tag);
    int c;
    c = cyc;
    iss_vld = 1'b1;
    iss_op  = 4'(op);
    iss_dbl = dbl;
    iss_dst = 3'(dst);
    push(c, 0, 0, int'(exp_stall), tag);
    if (exp_stall) begin
      push(c + 1, 1, dst, 1, "R7");
    end else if (chk) begin
      if (lat == 1) begin
        push(c + 1, 1, dst, 1, tag);
      end else begin
        push(c + 1, 1, dst, 0, tag);
        push(c + lat - 1, 1, dst, 0, tag);
        push(c + lat, 1, dst, 1, tag);
      end
    end
    step();
    iss_vld = 1'b0;
  endtask

  initial begin
    int b;
    rst_n   = 1'b0;
    iss_vld = 1'b0;
    iss_op  = '0;
    iss_dbl = 1'b0;
    iss_dst = '0;
    repeat (3) @(posedge clk);
    #1;
    push(cyc, 2, 0, 'hFF, "R1");
    push(cyc, 0, 0, 0, "R1");
    step();
    #1 rst_n = 1'b1;
    #1;
    push(cyc, 2, 0, 'hFF, "R1");
    push(cyc, 0, 0, 0, "R1");
    step();

    // non-iterative classes, including an unused code
    do_issue(0,  0, 1, 0, 1, 1, "R2");
    do_issue(1,  0, 2, 0, 2, 1, "R2");
    do_issue(2,  1, 3, 0, 3, 1, "R2");
    do_issue(3,  0, 4, 0, 3, 1, "R2");
    do_issue(4,  1, 5, 0, 4, 1, "R2");
    do_issue(12, 0, 6, 0, 1, 1, "R2");
    repeat (6) step();

    b = cyc;
    do_issue(5, 0, 1, 0, 5, 1, "R3");
    do_issue(5, 1, 2, 1, 9, 1, "R3");
    do_issue(5, 1, 2, 1, 9, 1, "R3");
    do_issue(6, 0, 3, 0, 36, 1, "R4");
    do_issue(8, 0, 4, 0, 21, 1, "R8");
    do_issue(0, 0, 5, 0, 1, 1, "R11");
    waitto(b + 24);
    do_issue(7, 0, 6, 1, 4, 1, "R9");
    do_issue(7, 1, 6, 0, 5, 1, "R5");
    do_issue(9, 0, 7, 1, 38, 1, "R9");
    do_issue(9, 0, 7, 0, 38, 1, "R6");
    waitto(b + 38);
    do_issue(6, 1, 0, 1, 68, 1, "R4");
    do_issue(6, 1, 0, 0, 68, 1, "R4");
    waitto(b + 64);
    do_issue(7, 0, 6, 1, 4, 1, "R9");
    do_issue(7, 0, 6, 0, 4, 1, "R5");
    do_issue(7, 0, 5, 0, 4, 1, "R5");
    do_issue(8, 1, 4, 0, 36, 1, "R6");
    waitto(b + 102);
    do_issue(9, 1, 3, 1, 68, 1, "R9");
    do_issue(9, 1, 3, 0, 68, 1, "R6");
    waitto(b + 106);
    do_issue(5, 0, 2, 1, 5, 1, "R4");
    do_issue(5, 1, 2, 0, 9, 1, "R3");
    waitto(b + 114);
    do_issue(6, 0, 1, 1, 36, 1, "R3");
    do_issue(5, 0, 1, 0, 5, 1, "R3");
    waitto(b + 120);
    // overwrite a long countdown with a short one
    do_issue(6, 0, 5, 0, 36, 0, "R10");
    push(b + 121, 1, 5, 0, "R10");
    do_issue(0, 0, 5, 0, 1, 1, "R10");
    push(b + 140, 1, 5, 1, "R10");
    waitto(b + 130);
    do_issue(5, 0, 1, 1, 5, 1, "R10");
    waitto(b + 180);

    if (q.size() != 0) begin
      bad++;
      $display("FAIL R7 pending expectations: actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule